// File: doc/BRIEF.md
# Register-Pair Arithmetic Unit

This block carries out the two 16-bit arithmetic operations that an 8-bit core performs on its register pairs. The first is a wide add: the working pair (HL) plus a second pair. The second is a wide subtract: HL minus the BC pair. The subtract runs as two chained byte steps, low byte first. Each byte step passes its borrow into the next step. The unit receives the current HL value, the second operand pair, the current flag byte and an operation code. It returns the new HL value and the new flag byte. Reading and writing the register file, and decoding instructions, belong to the surrounding core.

A request is offered with `req_valid` and is taken on a rising clock edge where `req_ready` is also high. `req_ready` falls on the edge that accepts a request and stays low until the last step of that operation has run. While `req_ready` is low the unit applies back-pressure, and `req_valid` together with the request fields is ignored. The result side has no ready signal. `rsp_valid` is high for exactly one cycle and the consumer must capture `rsp_hl` and `rsp_flags` on that cycle. Both stay stable until the next result.

With the default configuration, a wide add produces its response one cycle after acceptance. A wide subtract produces its response two cycles after acceptance: one cycle for the low byte step and one for the high byte step.

The flag byte uses fixed bit positions, because neighbouring logic decodes them:

| Bit | Meaning |
|-----|---------|
| 7 | sign |
| 6 | zero |
| 4 | half-carry |
| 2 | overflow |
| 1 | subtract |
| 0 | carry |

Top module: `pair_arith_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `req_ready` is 1, `rsp_valid` is 0, `rsp_hl` is 0x0000 and `rsp_flags` is 0x00.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 on the next cycle. While `req_ready` is 0, a raised `req_valid` is ignored: it does not change the pending result and it produces no additional response.
- R3: With `req_op` = 0 (wide add), `rsp_hl` equals (`req_hl` + `req_pair`) mod 65536. `rsp_valid` rises on the first cycle after the accepting edge.
- R4: For a wide add, `rsp_flags` bit 4 equals bit 12 of (`req_hl` XOR `req_pair` XOR sum) and bit 0 equals the carry out of bit 15. Bits 7, 6, 5, 3, 2 and 1 equal the same bits of `req_flags`.
- R5: With `req_op` = 1 (wide subtract), `rsp_hl` equals (`req_hl` − `req_pair`) mod 65536. The low bytes are subtracted first and the high-byte step subtracts that step's borrow. `rsp_valid` rises on the second cycle after the accepting edge.
- R6: For a wide subtract, `rsp_flags` is formed from the high byte step (H − B − low borrow = Rh):
  - bit 7 is Rh bit 7;
  - bit 4 is bit 4 of (H XOR B XOR Rh);
  - bit 2 is bit 7 of ((B XOR H) AND (H XOR Rh));
  - bit 1 is 1;
  - bit 0 is the borrow out of the high byte;
  - bits 5 and 3 are 0.
  
  `req_flags` has no effect on the result.
- R7: For a wide subtract, `rsp_flags` bit 6 is 1 exactly when the whole 16-bit result is zero. A nonzero low result byte clears it even when the high byte is zero.
- R8: `rsp_valid` is high for exactly one cycle per accepted request. `rsp_hl` and `rsp_flags` keep their values on every cycle where `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_op | input | 1 | 0 = wide add, 1 = wide subtract |
| req_hl | input | 16 | Current HL pair value |
| req_pair | input | 16 | Second operand pair (BC for subtract) |
| req_flags | input | 8 | Current flag byte |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hl | output | 16 | New HL pair value |
| rsp_flags | output | 8 | New flag byte |

## Verification
An internal fault in this block surfaces at the result port within one or two cycles of acceptance.

- A low-step borrow that is stored incorrectly, or never stored, shows as a high result byte that is off by one. The carry and half-carry bits from the high step are also wrong. Operand pairs whose low bytes borrow expose this.
- A stored low result byte that is wrong breaks the zero fix-up. An operand pair whose result has a zero high byte and a nonzero low byte shows this in bit 6.
- A sequencer that skips or repeats a step shows up in three ways: `rsp_valid` arrives a cycle early or late, a second response pulse appears, or `req_ready` rises while an operation is still in progress.
- A flag byte that is latched at the wrong time corrupts the bits that a wide add must carry through unchanged.

// File: rtl/pairarith_pkg.sv
package pairarith_pkg;

  localparam int FLAG_W  = 8;
  localparam int F_SIGN  = 7;
  localparam int F_ZERO  = 6;
  localparam int F_HALF  = 4;
  localparam int F_OVF   = 2;
  localparam int F_SUBT  = 1;
  localparam int F_CARRY = 0;

  typedef enum logic {
    PA_DADD = 1'b0,
    PA_DSUB = 1'b1
  } pa_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADD    = 2'd1,
    ST_SUB_LO = 2'd2,
    ST_SUB_HI = 2'd3
  } pa_state_e;

endpackage

// File: rtl/pa_pair_add.sv
module pa_pair_add
  import pairarith_pkg::*;
#(
  parameter int PAIR_W = 16
) (
  input  logic [PAIR_W-1:0] a,
  input  logic [PAIR_W-1:0] b,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [PAIR_W-1:0] sum,
  output logic [FLAG_W-1:0] flags_out
);
  // carry into the top nibble of the pair
  localparam int HC_BIT = PAIR_W - PAIR_W / 4;

  logic [PAIR_W:0] full;

  assign full = {1'b0, a} + {1'b0, b};
  assign sum  = full[PAIR_W-1:0];

  always_comb begin
    flags_out          = flags_in;
    flags_out[F_HALF]  = a[HC_BIT] ^ b[HC_BIT] ^ full[HC_BIT];
    flags_out[F_CARRY] = full[PAIR_W];
  end
endmodule

// File: rtl/pa_byte_sub.sv
module pa_byte_sub
  import pairarith_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              borrow_in,
  output logic [BYTE_W-1:0] diff,
  output logic              borrow_out,
  output logic [FLAG_W-1:0] flags
);
  localparam int HB  = BYTE_W / 2;
  localparam int MSB = BYTE_W - 1;

  logic [BYTE_W:0] full;

  assign full       = {1'b0, a} - {1'b0, b} - {{BYTE_W{1'b0}}, borrow_in};
  assign diff       = full[BYTE_W-1:0];
  assign borrow_out = full[BYTE_W];

  // Sign, zero, half-borrow, overflow, subtract and borrow; no parity.
  always_comb begin
    flags          = '0;
    flags[F_SIGN]  = diff[MSB];
    flags[F_ZERO]  = (diff == '0);
    flags[F_HALF]  = a[HB] ^ b[HB] ^ diff[HB];
    flags[F_OVF]   = (a[MSB] ^ b[MSB]) & (a[MSB] ^ diff[MSB]);
    flags[F_SUBT]  = 1'b1;
    flags[F_CARRY] = borrow_out;
  end
endmodule

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import pairarith_pkg::*;
#(
  parameter bit SPLIT_SUB = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      req_op,
  output logic      req_ready,
  output logic      accept,
  output logic      finish,
  output pa_state_e state
);
  pa_state_e nxt;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign finish    = (state == ST_ADD) || (state == ST_SUB_HI);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (pa_op_e'(req_op) == PA_DADD) nxt = ST_ADD;
          else if (SPLIT_SUB)              nxt = ST_SUB_LO;
          else                             nxt = ST_SUB_HI;
        end
      end
      ST_ADD:    nxt = ST_IDLE;
      ST_SUB_LO: nxt = ST_SUB_HI;
      ST_SUB_HI: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/pair_arith_unit.sv
module pair_arith_unit
  import pairarith_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter bit SPLIT_SUB = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_op,
  input  logic [2*BYTE_W-1:0]   req_hl,
  input  logic [2*BYTE_W-1:0]   req_pair,
  input  logic [FLAG_W-1:0]     req_flags,
  output logic                  rsp_valid,
  output logic [2*BYTE_W-1:0]   rsp_hl,
  output logic [FLAG_W-1:0]     rsp_flags
);
  localparam int PAIR_W = 2 * BYTE_W;

  pa_state_e             state;
  logic                  accept;
  logic                  finish;
  pa_op_e                op_q;
  logic [PAIR_W-1:0]     hl_q;
  logic [PAIR_W-1:0]     pair_q;
  logic [FLAG_W-1:0]     flags_q;
  logic [PAIR_W-1:0]     add_sum;
  logic [FLAG_W-1:0]     add_flags;
  logic [BYTE_W-1:0]     sub_lo_diff;
  logic [BYTE_W-1:0]     sub_hi_diff;
  logic [FLAG_W-1:0]     sub_hi_flags;
  logic [FLAG_W-1:0]     sub_flags;

  pa_ctrl #(.SPLIT_SUB(SPLIT_SUB)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .accept    (accept),
    .finish    (finish),
    .state     (state)
  );

  // operand capture on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= PA_DADD;
      hl_q    <= '0;
      pair_q  <= '0;
      flags_q <= '0;
    end else if (accept) begin
      op_q    <= pa_op_e'(req_op);
      hl_q    <= req_hl;
      pair_q  <= req_pair;
      flags_q <= req_flags;
    end
  end

  pa_pair_add #(.PAIR_W(PAIR_W)) u_add (
    .a         (hl_q),
    .b         (pair_q),
    .flags_in  (flags_q),
    .sum       (add_sum),
    .flags_out (add_flags)
  );

  generate
    if (SPLIT_SUB) begin : g_split
      // one byte subtractor reused for the low and the high step
      logic              lo_borrow_q;
      logic [BYTE_W-1:0] lo_diff_q;
      logic              hi_phase;
      logic [BYTE_W-1:0] step_a;
      logic [BYTE_W-1:0] step_b;
      logic              step_bin;
      logic [BYTE_W-1:0] step_diff;
      logic              step_bout;
      logic [FLAG_W-1:0] step_flags;

      assign hi_phase = (state == ST_SUB_HI);
      assign step_a   = hi_phase ? hl_q[PAIR_W-1:BYTE_W]   : hl_q[BYTE_W-1:0];
      assign step_b   = hi_phase ? pair_q[PAIR_W-1:BYTE_W] : pair_q[BYTE_W-1:0];
      assign step_bin = hi_phase & lo_borrow_q;

      pa_byte_sub #(.BYTE_W(BYTE_W)) u_step (
        .a          (step_a),
        .b          (step_b),
        .borrow_in  (step_bin),
        .diff       (step_diff),
        .borrow_out (step_bout),
        .flags      (step_flags)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_borrow_q <= 1'b0;
          lo_diff_q   <= '0;
        end else if (state == ST_SUB_LO) begin
          lo_borrow_q <= step_bout;
          lo_diff_q   <= step_diff;
        end
      end

      assign sub_lo_diff  = lo_diff_q;
      assign sub_hi_diff  = step_diff;
      assign sub_hi_flags = step_flags;
    end else begin : g_flat
      // both byte steps chained in a single cycle
      logic              lo_bout;
      logic [FLAG_W-1:0] lo_flags;
      logic              hi_bout;

      pa_byte_sub #(.BYTE_W(BYTE_W)) u_lo (
        .a          (hl_q[BYTE_W-1:0]),
        .b          (pair_q[BYTE_W-1:0]),
        .borrow_in  (1'b0),
        .diff       (sub_lo_diff),
        .borrow_out (lo_bout),
        .flags      (lo_flags)
      );

      pa_byte_sub #(.BYTE_W(BYTE_W)) u_hi (
        .a          (hl_q[PAIR_W-1:BYTE_W]),
        .b          (pair_q[PAIR_W-1:BYTE_W]),
        .borrow_in  (lo_bout),
        .diff       (sub_hi_diff),
        .borrow_out (hi_bout),
        .flags      (sub_hi_flags)
      );
    end
  endgenerate

  // zero must reflect the whole pair, not just the high byte
  always_comb begin
    sub_flags = sub_hi_flags;
    if (sub_lo_diff != '0) sub_flags[F_ZERO] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hl    <= '0;
      rsp_flags <= '0;
    end else begin
      rsp_valid <= finish;
      if (finish) begin
        if (op_q == PA_DADD) begin
          rsp_hl    <= add_sum;
          rsp_flags <= add_flags;
        end else begin
          rsp_hl    <= {sub_hi_diff, sub_lo_diff};
          rsp_flags <= sub_flags;
        end
      end
    end
  end
endmodule

// File: rtl/pair_arith_unit_chk.sv
module pair_arith_unit_chk #(
  parameter int PAIR_W    = 16,
  parameter bit SPLIT_SUB = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_op,
  input logic [7:0]        req_flags,
  input logic              rsp_valid,
  input logic [PAIR_W-1:0] rsp_hl,
  input logic [7:0]        rsp_flags
);
  logic take_add;
  logic take_sub;

  assign take_add = req_valid && req_ready && !req_op;
  assign take_sub = req_valid && req_ready && req_op;

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !rsp_valid && rsp_hl == '0 && rsp_flags == 8'h00));

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_add_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_add |=> !rsp_valid ##1 rsp_valid);

  p_add_keeps_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(take_add, 2)) |->
      ((rsp_flags & 8'hEE) == ($past(req_flags, 2) & 8'hEE)));

  generate
    if (SPLIT_SUB) begin : g_split_chk
      p_sub_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_sub |=> !rsp_valid ##1 !rsp_valid ##1 rsp_valid);

      p_sub_fixed_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(take_sub, 3)) |->
          (rsp_flags[1] && !rsp_flags[5] && !rsp_flags[3]));

      p_sub_zero_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(take_sub, 3)) |-> (rsp_flags[6] == (rsp_hl == '0)));
    end
  endgenerate

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ($stable(rsp_hl) && $stable(rsp_flags)));
endmodule

bind pair_arith_unit pair_arith_unit_chk #(
  .PAIR_W    (2 * BYTE_W),
  .SPLIT_SUB (SPLIT_SUB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_flags (req_flags),
  .rsp_valid (rsp_valid),
  .rsp_hl    (rsp_hl),
  .rsp_flags (rsp_flags)
);

// File: tb/pair_arith_unit_bench.sv
`timescale 1ns/1ps
module pair_arith_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [15:0] req_hl = '0;
  logic [15:0] req_pair = '0;
  logic [7:0]  req_flags = '0;
  logic        rsp_valid;
  logic [15:0] rsp_hl;
  logic [7:0]  rsp_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pair_arith_unit u_pair_arith_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_hl    (req_hl),
    .req_pair  (req_pair),
    .req_flags (req_flags),
    .rsp_valid (rsp_valid),
    .rsp_hl    (rsp_hl),
    .rsp_flags (rsp_flags)
  );

  // op, hl, pair, flags_in, expected hl, expected flags
  localparam int NVEC = 9;
  localparam logic [64:0] VECS [0:NVEC-1] = '{
    {1'b0, 16'h1234, 16'h1111, 8'h00, 16'h2345, 8'h00},
    {1'b0, 16'h0FFF, 16'h0001, 8'hFF, 16'h1000, 8'hFE},
    {1'b0, 16'hFFFF, 16'h0001, 8'h00, 16'h0000, 8'h11},
    {1'b0, 16'h8000, 16'h8000, 8'hC4, 16'h0000, 8'hC5},
    {1'b1, 16'h1234, 16'h1234, 8'h00, 16'h0000, 8'h42},
    {1'b1, 16'h0000, 16'h0001, 8'hFF, 16'hFFFF, 8'h93},
    {1'b1, 16'h0100, 16'h0001, 8'h00, 16'h00FF, 8'h02},
    {1'b1, 16'h8000, 16'h0001, 8'h00, 16'h7FFF, 8'h16},
    {1'b1, 16'h5000, 16'h6000, 8'h00, 16'hF000, 8'h83}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input logic [15:0] hl, input logic [15:0] pr,
                        input logic [7:0] fl, input logic [15:0] ehl, input logic [7:0] efl);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_hl = hl; req_pair = pr; req_flags = fl;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 6) begin
      @(negedge clk);
      lat++;
    end
    if (op) begin
      chk("R5 latency", lat, 2);
      chk("R5 result", rsp_hl, ehl);
      chk("R6 flags", rsp_flags & 8'hBF, efl & 8'hBF);
      chk("R7 zero", rsp_flags[6], efl[6]);
    end else begin
      chk("R3 latency", lat, 1);
      chk("R3 result", rsp_hl, ehl);
      chk("R4 flags", rsp_flags, efl);
    end
    @(negedge clk);
    chk("R8 pulse", rsp_valid, 0);
  endtask

  initial begin
    #160000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held_hl;
    logic [7:0]  held_fl;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", req_ready, 1);
    chk("R1 valid", rsp_valid, 0);
    chk("R1 hl", rsp_hl, 0);
    chk("R1 flags", rsp_flags, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", req_ready, 1);

    for (int i = 0; i < NVEC; i++) begin
      logic [64:0] v;
      v = VECS[i];
      run_op(v[64], v[63:48], v[47:32], v[31:24], v[23:8], v[7:0]);
    end

    // R2: strobe while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_op = 1'b1; req_hl = 16'h1234; req_pair = 16'h0234; req_flags = 8'h00;
    @(posedge clk);
    @(negedge clk);
    chk("R2 busy", req_ready, 0);
    req_op = 1'b0; req_hl = 16'hFFFF; req_pair = 16'hFFFF; req_flags = 8'hFF;
    @(negedge clk);
    chk("R2 busy", req_ready, 0);
    chk("R2 no early rsp", rsp_valid, 0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R2 rsp", rsp_valid, 1);
    chk("R2 hl unaffected", rsp_hl, 16'h1000);
    chk("R2 flags unaffected", rsp_flags, 8'h02);
    @(negedge clk);
    chk("R2 no extra rsp", rsp_valid, 0);
    @(negedge clk);
    chk("R2 no extra rsp", rsp_valid, 0);

    // R8: outputs hold while idle
    held_hl = rsp_hl;
    held_fl = rsp_flags;
    req_hl = 16'hAAAA; req_pair = 16'h5555;
    repeat (3) @(negedge clk);
    chk("R8 hold hl", rsp_hl, held_hl);
    chk("R8 hold flags", rsp_flags, held_fl);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule